// File: doc/BRIEF.md
# USB Handshake Interrupt Filter

This block sits beside a USB device controller's transaction engine and decides, per endpoint, whether a finished transaction should raise an interrupt. The engine reports every completed transaction as a one-cycle strobe. The strobe carries the handshake that closed the transaction (ACK, NAK or NYET), the token direction (control, data IN or data OUT) and the endpoint number. A qualifying transaction sets that endpoint's pending flag. Software clears the flag by writing a 1 to it.

Each of the three directions has its own two-bit policy. A policy can let every NAK through, block all NAKs, or let through only the first NAK that follows an ACK on that endpoint. On OUT tokens a NYET counts the same as an ACK. One armed bit per endpoint records whether a NAK would now be the first one.

The block also drives the external interrupt pin. In level mode the pin stays asserted while any enabled endpoint has a pending flag. In pulse mode each qualifying transaction on an enabled endpoint produces a pulse of fixed width. The width is derived from the clock period so that it lasts at least 60 ns. Pulses that arrive during a pulse are queued and played out with a one-cycle gap between them. The polarity of the pin is selectable.

Top module: `usb_irq_filter`

## Requirements
- R1: After the asynchronous reset, all pending flags are 0 and all enables are 0. The configuration reads 8'h00, which means all policies 00, level mode and active-low. The pin is therefore high.
- R2: A strobe with handshake ACK (code 0) and direction control (0), IN (1) or OUT (2) sets the pending flag of its endpoint at the next clock edge, whatever the policy. Direction code 3 has no effect.
- R3: When the policy of the strobe's direction is 00, a NAK (code 1) sets the endpoint's pending flag.
- R4: When the policy of the strobe's direction is 01, a NAK is ignored: the pending flags do not change.
- R5: When the policy of the strobe's direction is 10 or 11, a NAK sets the pending flag only if the endpoint is armed. An endpoint becomes armed on an ACK, or on a NYET with an OUT token. Any NAK disarms it. Every endpoint is disarmed after reset.
- R6: A NYET (code 2) with an OUT token behaves like an ACK. A NYET with a control or IN token neither sets a flag nor changes the armed bit.
- R7: The configuration byte holds the control policy in bits 7:6, the IN policy in bits 5:4 and the OUT policy in bits 3:2. Bit 1 selects pulse mode (1) or level mode (0). Bit 0 selects active-high (1) or active-low (0). Each policy applies only to its own direction.
- R8: Writing a 1 to a bit of the clear port clears that endpoint's pending flag at the next edge. A qualifying event in the same cycle wins, and the flag stays set.
- R9: In level mode the pin is asserted in the same cycle that any enabled endpoint's flag is set. It deasserts once no enabled flag remains, and bit 0 sets its polarity.
- R10: In pulse mode, each qualifying event on an enabled endpoint asserts the pin for PULSE_CYC cycles, with PULSE_CYC = ceil(60 ns / clock period). The pulse starts one edge after the flag sets. Queued pulses follow one another with exactly one deasserted cycle between them.
- R11: A bus reset strobe sets all three policies to 00 and disarms every endpoint. It leaves the mode bit, the polarity bit, the enables and the pending flags unchanged.
- R12: An event on an endpoint whose enable bit is 0 still sets its pending flag. It neither asserts the level pin nor queues a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous controller reset, active low |
| bus_rst | input | 1 | One-cycle USB bus reset strobe |
| ev_valid | input | 1 | Transaction-completed strobe |
| ev_hs | input | 2 | Handshake: 0 ACK, 1 NAK, 2 NYET, 3 none |
| ev_dir | input | 2 | Token: 0 control, 1 IN, 2 OUT, 3 none |
| ev_ep | input | EP_W | Endpoint index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| en_we | input | 1 | Enable-mask write strobe |
| en_wdata | input | NUM_EP | Enable-mask write data |
| clr_we | input | 1 | Pending-clear strobe |
| clr_wdata | input | NUM_EP | Write-1-to-clear bits |
| cfg_rdata | output | 8 | Current configuration byte |
| pend | output | NUM_EP | Per-endpoint pending flags |
| int_pin | output | 1 | Interrupt pin |

## Verification
The pending flags and the configuration readback change one clock edge after the cycle in which the strobe or write is presented. The level-mode pin follows the flags in that same cycle. A pulse starts one edge later than its flag and lasts PULSE_CYC cycles. The bench drives inputs on the falling edge and lets one rising edge pass. On every falling edge it compares all outputs against a behavioural model that is advanced on the same rising edges. Directed checks are placed at the falling edge right after each stimulus. For pulse mode, the bench counts rises, asserted cycles and the spacing of rises over a window.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  typedef enum logic [1:0] {
    HS_ACK  = 2'd0,
    HS_NAK  = 2'd1,
    HS_NYET = 2'd2,
    HS_NONE = 2'd3
  } hs_e;

  typedef enum logic [1:0] {
    DIR_CTRL = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2,
    DIR_NONE = 2'd3
  } dir_e;

  localparam logic [1:0] POLICY_ALL_NAK = 2'b00;
  localparam logic [1:0] POLICY_NO_NAK  = 2'b01;

  // Decide whether a completed transaction raises the endpoint flag.
  function automatic logic irq_due(input logic [1:0] hs, input logic [1:0] dir,
                                   input logic [1:0] policy, input logic armed);
    logic due;
    due = 1'b0;
    if (dir != DIR_NONE) begin
      case (hs)
        HS_ACK:  due = 1'b1;
        HS_NYET: due = (dir == DIR_OUT);
        HS_NAK: begin
          if (policy == POLICY_ALL_NAK)     due = 1'b1;
          else if (policy == POLICY_NO_NAK) due = 1'b0;
          else                              due = armed;
        end
        default: due = 1'b0;
      endcase
    end
    return due;
  endfunction

  // Next value of the first-NAK tracking bit.
  function automatic logic arm_after(input logic [1:0] hs, input logic [1:0] dir,
                                     input logic armed);
    logic nxt;
    nxt = armed;
    if (dir != DIR_NONE) begin
      if (hs == HS_ACK)                         nxt = 1'b1;
      else if (hs == HS_NYET && dir == DIR_OUT) nxt = 1'b1;
      else if (hs == HS_NAK)                    nxt = 1'b0;
    end
    return nxt;
  endfunction

  // Smallest whole number of clock cycles covering the minimum pulse time.
  function automatic int unsigned pulse_cycles(input int unsigned min_ps,
                                               input int unsigned clk_ps);
    int unsigned n;
    n = (min_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/usb_irq_cfg.sv
module usb_irq_cfg
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              en_we,
  input  logic [NUM_EP-1:0] en_wdata,
  output logic [1:0]        pol_ctrl,
  output logic [1:0]        pol_in,
  output logic [1:0]        pol_out,
  output logic              pulse_mode,
  output logic              act_high,
  output logic [NUM_EP-1:0] ep_en,
  output logic [7:0]        cfg_rdata
);

  logic [1:0]        f_ctrl, f_in, f_out;
  logic              f_pulse, f_high;
  logic [NUM_EP-1:0] f_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_ctrl  <= '0;
      f_in    <= '0;
      f_out   <= '0;
      f_pulse <= 1'b0;
      f_high  <= 1'b0;
      f_en    <= '0;
    end else begin
      if (bus_rst) begin
        f_ctrl <= '0;
        f_in   <= '0;
        f_out  <= '0;
      end else if (cfg_we) begin
        f_ctrl <= cfg_wdata[7:6];
        f_in   <= cfg_wdata[5:4];
        f_out  <= cfg_wdata[3:2];
      end
      if (cfg_we) begin
        f_pulse <= cfg_wdata[1];
        f_high  <= cfg_wdata[0];
      end
      if (en_we) f_en <= en_wdata;
    end
  end

  assign pol_ctrl   = f_ctrl;
  assign pol_in     = f_in;
  assign pol_out    = f_out;
  assign pulse_mode = f_pulse;
  assign act_high   = f_high;
  assign ep_en      = f_en;
  assign cfg_rdata  = {f_ctrl, f_in, f_out, f_pulse, f_high};

  AST_BUSRST_POLICY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (cfg_rdata[7:2] == 6'd0)) else $error("bus reset left a policy set"); // R11

  AST_BUSRST_PIN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !cfg_we && !en_we) |=> ($stable(cfg_rdata[1:0]) && $stable(ep_en)))
    else $error("bus reset touched pin settings"); // R11

endmodule

// File: rtl/usb_irq_ep_track.sv
module usb_irq_ep_track
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              ev_valid,
  input  logic [1:0]        ev_hs,
  input  logic [1:0]        ev_dir,
  input  logic [EP_W-1:0]   ev_ep,
  input  logic [1:0]        pol_ctrl,
  input  logic [1:0]        pol_in,
  input  logic [1:0]        pol_out,
  input  logic              clr_we,
  input  logic [NUM_EP-1:0] clr_wdata,
  output logic [NUM_EP-1:0] pend,
  output logic              ev_hit
);

  logic [1:0]        pol_sel;
  logic [NUM_EP-1:0] armed;
  logic              armed_sel;

  always_comb begin
    case (ev_dir)
      DIR_CTRL: pol_sel = pol_ctrl;
      DIR_IN:   pol_sel = pol_in;
      default:  pol_sel = pol_out;
    endcase
  end

  assign armed_sel = armed[ev_ep];
  assign ev_hit    = ev_valid && irq_due(ev_hs, ev_dir, pol_sel, armed_sel);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic sel_i, arm_q, pend_q;
    assign sel_i = ev_valid && (ev_ep == EP_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arm_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (bus_rst)    arm_q <= 1'b0;
        else if (sel_i) arm_q <= arm_after(ev_hs, ev_dir, arm_q);
        if (sel_i && ev_hit)                pend_q <= 1'b1;
        else if (clr_we && clr_wdata[i])    pend_q <= 1'b0;
      end
    end

    assign armed[i] = arm_q;
    assign pend[i]  = pend_q;
  end

  AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_hs == HS_ACK && ev_dir != DIR_NONE) |=> pend[$past(ev_ep)])
    else $error("ACK did not set pending"); // R2

  AST_NO_NAK_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_hs == HS_NAK && pol_sel == POLICY_NO_NAK) |-> !ev_hit)
    else $error("NAK passed an ACK-only policy"); // R4

  AST_NAK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_hs == HS_NAK && ev_dir != DIR_NONE) |=> !armed[$past(ev_ep)])
    else $error("NAK left endpoint armed"); // R5

  AST_NYET_OUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_hs == HS_NYET && ev_dir != DIR_OUT) |-> !ev_hit)
    else $error("NYET outside OUT raised a flag"); // R6

endmodule

// File: rtl/usb_irq_pin.sv
module usb_irq_pin #(
  parameter int PULSE_CYC = 3,
  parameter int BACKLOG_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_req,
  input  logic level_act,
  input  logic pulse_mode,
  input  logic act_high,
  output logic pulse_on,
  output logic int_pin
);

  localparam int TMR_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [BACKLOG_W-1:0] BL_MAX = '1;

  typedef enum logic [1:0] {PS_IDLE, PS_ON, PS_GAP} pstate_e;

  pstate_e              st;
  logic [TMR_W-1:0]     tmr;
  logic [BACKLOG_W-1:0] backlog;
  logic                 take;
  logic                 asserted;

  assign take = (st != PS_ON) && (backlog != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PS_IDLE;
      tmr     <= '0;
      backlog <= '0;
    end else begin
      case (st)
        PS_ON: begin
          if (tmr == '0) st <= PS_GAP;
          else           tmr <= tmr - 1'b1;
        end
        default: begin
          if (take) begin
            st  <= PS_ON;
            tmr <= TMR_W'(PULSE_CYC - 1);
          end else begin
            st <= PS_IDLE;
          end
        end
      endcase
      if (pulse_req && !take && backlog != BL_MAX) backlog <= backlog + 1'b1;
      else if (!pulse_req && take)                 backlog <= backlog - 1'b1;
    end
  end

  assign pulse_on = (st == PS_ON);
  assign asserted = pulse_mode ? pulse_on : level_act;
  assign int_pin  = act_high ? asserted : ~asserted;

  AST_PULSE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> ($past(backlog) != '0))
    else $error("pulse started with nothing queued"); // R10

  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_GAP) |=> (st != PS_GAP))
    else $error("gap longer than one cycle"); // R10

endmodule

// File: rtl/usb_irq_filter.sv
module usb_irq_filter
  import usb_irq_pkg::*;
#(
  parameter int          NUM_EP        = 8,
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned PULSE_MIN_PS  = 60000,
  parameter int          BACKLOG_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_rst,
  input  logic                       ev_valid,
  input  logic [1:0]                 ev_hs,
  input  logic [1:0]                 ev_dir,
  input  logic [$clog2(NUM_EP)-1:0]  ev_ep,
  input  logic                       cfg_we,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       en_we,
  input  logic [NUM_EP-1:0]          en_wdata,
  input  logic                       clr_we,
  input  logic [NUM_EP-1:0]          clr_wdata,
  output logic [7:0]                 cfg_rdata,
  output logic [NUM_EP-1:0]          pend,
  output logic                       int_pin
);

  localparam int EP_W      = $clog2(NUM_EP);
  localparam int PULSE_CYC = int'(pulse_cycles(PULSE_MIN_PS, CLK_PERIOD_PS));

  logic [1:0]        pol_ctrl, pol_in, pol_out;
  logic              pulse_mode, act_high;
  logic [NUM_EP-1:0] ep_en;
  logic              ev_hit;
  logic              pulse_req;
  logic              level_act;
  logic              pulse_on;

  usb_irq_cfg #(.NUM_EP(NUM_EP)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst    (bus_rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .en_we      (en_we),
    .en_wdata   (en_wdata),
    .pol_ctrl   (pol_ctrl),
    .pol_in     (pol_in),
    .pol_out    (pol_out),
    .pulse_mode (pulse_mode),
    .act_high   (act_high),
    .ep_en      (ep_en),
    .cfg_rdata  (cfg_rdata)
  );

  usb_irq_ep_track #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst   (bus_rst),
    .ev_valid  (ev_valid),
    .ev_hs     (ev_hs),
    .ev_dir    (ev_dir),
    .ev_ep     (ev_ep),
    .pol_ctrl  (pol_ctrl),
    .pol_in    (pol_in),
    .pol_out   (pol_out),
    .clr_we    (clr_we),
    .clr_wdata (clr_wdata),
    .pend      (pend),
    .ev_hit    (ev_hit)
  );

  assign pulse_req = ev_hit && ep_en[ev_ep] && pulse_mode;
  assign level_act = |(pend & ep_en);

  usb_irq_pin #(.PULSE_CYC(PULSE_CYC), .BACKLOG_W(BACKLOG_W)) u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_req  (pulse_req),
    .level_act  (level_act),
    .pulse_mode (pulse_mode),
    .act_high   (act_high),
    .pulse_on   (pulse_on),
    .int_pin    (int_pin)
  );

  AST_MASKED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ep_en[ev_ep]) |-> !pulse_req)
    else $error("masked endpoint queued a pulse"); // R12

endmodule

// File: tb/usb_irq_filter_tb.sv
`timescale 1ns/1ps
module usb_irq_filter_tb;

  localparam int CLK_PERIOD = 20;
  localparam int NEP        = 8;
  localparam int MIN_NS     = 60;
  localparam int BL_LIMIT   = 15;

  localparam bit [1:0] ACK = 2'd0, NAK = 2'd1, NYET = 2'd2;
  localparam bit [1:0] CTL = 2'd0, DIN = 2'd1, DOUT = 2'd2;

  function automatic int width_cycles();
    int c = 0;
    while (c * CLK_PERIOD < MIN_NS) c++;
    return c;
  endfunction
  localparam int P = width_cycles();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_hs = 2'd0, ev_dir = 2'd0;
  logic [2:0] ev_ep = 3'd0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'd0;
  logic en_we = 1'b0;
  logic [7:0] en_wdata = 8'd0;
  logic clr_we = 1'b0;
  logic [7:0] clr_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic [7:0] pend;
  logic int_pin;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_filter #(
    .NUM_EP(NEP), .CLK_PERIOD_PS(CLK_PERIOD*1000), .PULSE_MIN_PS(MIN_NS*1000), .BACKLOG_W(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .ev_valid(ev_valid), .ev_hs(ev_hs),
    .ev_dir(ev_dir), .ev_ep(ev_ep), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .en_we(en_we),
    .en_wdata(en_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata), .cfg_rdata(cfg_rdata),
    .pend(pend), .int_pin(int_pin)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // Behavioural reference state
  bit [7:0] m_pend, m_arm, m_en;
  bit [1:0] m_pc, m_pi, m_po;
  bit m_pm, m_hi;
  int m_back, m_left;
  bit [1:0] t_pol;
  bit t_hit, t_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_arm = 0; m_en = 0; m_pc = 0; m_pi = 0; m_po = 0;
      m_pm = 0; m_hi = 0; m_back = 0; m_left = 0;
    end else begin
      t_hit = 0;
      if (ev_valid && ev_dir != 2'd3) begin
        t_pol = (ev_dir == CTL) ? m_pc : (ev_dir == DIN) ? m_pi : m_po;
        if (ev_hs == ACK) t_hit = 1;
        else if (ev_hs == NYET) t_hit = (ev_dir == DOUT);
        else if (ev_hs == NAK) t_hit = (t_pol == 0) ? 1'b1 : (t_pol == 1) ? 1'b0 : m_arm[ev_ep];
      end
      t_req = t_hit && m_en[ev_ep] && m_pm;
      if (m_left > 0) m_left--;
      else if (m_back > 0) begin m_left = P; m_back--; end
      if (t_req && m_back < BL_LIMIT) m_back++;
      if (clr_we) m_pend = m_pend & ~clr_wdata;
      if (t_hit) m_pend[ev_ep] = 1'b1;
      if (ev_valid && ev_dir != 2'd3) begin
        if (ev_hs == ACK || (ev_hs == NYET && ev_dir == DOUT)) m_arm[ev_ep] = 1'b1;
        else if (ev_hs == NAK) m_arm[ev_ep] = 1'b0;
      end
      if (bus_rst) begin m_arm = 0; m_pc = 0; m_pi = 0; m_po = 0; end
      else if (cfg_we) begin m_pc = cfg_wdata[7:6]; m_pi = cfg_wdata[5:4]; m_po = cfg_wdata[3:2]; end
      if (cfg_we) begin m_pm = cfg_wdata[1]; m_hi = cfg_wdata[0]; end
      if (en_we) m_en = en_wdata;
    end
  end

  function automatic bit model_pin();
    bit act;
    act = m_pm ? (m_left > 0) : (|(m_pend & m_en));
    return m_hi ? act : !act;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model (requirement of the running phase)
  always @(negedge clk) begin
    chk({cur_req, " pend"}, 32'(pend), 32'(m_pend));
    chk({cur_req, " pin"}, 32'(int_pin), 32'(model_pin()));
    chk({cur_req, " cfg"}, 32'(cfg_rdata), 32'({m_pc, m_pi, m_po, m_pm, m_hi}));
  end

  // Pulse observation counters
  bit cnt_en = 0;
  int cyc = 0, rises = 0, highs = 0, first_rise = -1, last_rise = -1;
  bit prev_pin = 0;
  always @(negedge clk) begin
    cyc++;
    if (cnt_en) begin
      if (int_pin) highs++;
      if (int_pin && !prev_pin) begin
        rises++;
        if (first_rise < 0) first_rise = cyc;
        last_rise = cyc;
      end
    end
    prev_pin = int_pin;
  end

  task automatic count_start();
    rises = 0; highs = 0; first_rise = -1; last_rise = -1; cnt_en = 1;
  endtask

  task automatic ev(input bit [1:0] hs, input bit [1:0] dir, input int ep);
    ev_valid = 1; ev_hs = hs; ev_dir = dir; ev_ep = 3'(ep);
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic ev_clr(input bit [1:0] hs, input bit [1:0] dir, input int ep, input bit [7:0] c);
    clr_we = 1; clr_wdata = c;
    ev(hs, dir, ep);
    clr_we = 0;
  endtask

  task automatic wr_cfg(input bit [7:0] d);
    cfg_we = 1; cfg_wdata = d; @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_en(input bit [7:0] d);
    en_we = 1; en_wdata = d; @(negedge clk); en_we = 0;
  endtask

  task automatic wr_clr(input bit [7:0] d);
    clr_we = 1; clr_wdata = d; @(negedge clk); clr_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 pend after reset", 32'(pend), 32'h00);
    chk("R1 pin after reset", 32'(int_pin), 32'h1);
    chk("R1 cfg after reset", 32'(cfg_rdata), 32'h00);

    cur_req = "R2";
    wr_en(8'hFF);
    ev(ACK, DIN, 3);
    chk("R2 ACK sets flag", 32'(pend), 32'h08);
    chk("R9 level pin low active", 32'(int_pin), 32'h0);
    ev(ACK, 2'd3, 5);
    chk("R2 dir code 3 ignored", 32'(pend), 32'h08);

    cur_req = "R8";
    wr_clr(8'h08);
    chk("R8 write-1 clears", 32'(pend), 32'h00);
    chk("R9 pin released", 32'(int_pin), 32'h1);

    cur_req = "R4";
    wr_cfg(8'h10);
    ev(NAK, DIN, 2);
    chk("R4 NAK ignored", 32'(pend), 32'h00);
    chk("R4 pin untouched", 32'(int_pin), 32'h1);

    cur_req = "R3";
    ev(NAK, DOUT, 1);
    chk("R3 NAK passes policy 00", 32'(pend), 32'h02);
    wr_clr(8'hFF);

    cur_req = "R5";
    wr_cfg(8'h20);
    ev(NAK, DIN, 4);
    chk("R5 NAK before any ACK", 32'(pend), 32'h00);
    ev(ACK, DIN, 4);
    chk("R5 ACK arms and sets", 32'(pend), 32'h10);
    wr_clr(8'hFF);
    ev(NAK, DIN, 4);
    chk("R5 first NAK passes", 32'(pend), 32'h10);
    wr_clr(8'hFF);
    ev(NAK, DIN, 4);
    chk("R5 second NAK blocked", 32'(pend), 32'h00);

    cur_req = "R6";
    wr_cfg(8'h2C);
    ev(NYET, DOUT, 5);
    chk("R6 NYET on OUT sets", 32'(pend), 32'h20);
    wr_clr(8'hFF);
    ev(NAK, DOUT, 5);
    chk("R6 NYET armed OUT", 32'(pend), 32'h20);
    wr_clr(8'hFF);
    ev(NYET, DIN, 6);
    chk("R6 NYET on IN ignored", 32'(pend), 32'h00);
    ev(NAK, DIN, 6);
    chk("R6 NYET on IN did not arm", 32'(pend), 32'h00);

    cur_req = "R7";
    wr_cfg(8'h44);
    ev(NAK, CTL, 0);
    chk("R7 control field 01", 32'(pend), 32'h00);
    ev(NAK, DIN, 0);
    chk("R7 IN field 00", 32'(pend), 32'h01);
    ev(NAK, DOUT, 7);
    chk("R7 OUT field 01", 32'(pend), 32'h01);
    wr_clr(8'hFF);

    cur_req = "R8";
    ev(ACK, CTL, 2);
    ev_clr(ACK, CTL, 2, 8'h04);
    chk("R8 set beats clear", 32'(pend), 32'h04);
    wr_clr(8'hFF);

    cur_req = "R12";
    wr_en(8'hFD);
    ev(ACK, DIN, 1);
    chk("R12 masked flag set", 32'(pend), 32'h02);
    chk("R12 masked pin idle", 32'(int_pin), 32'h1);

    cur_req = "R9";
    wr_cfg(8'h01);
    chk("R9 active-high idle", 32'(int_pin), 32'h0);
    wr_en(8'hFF);
    chk("R9 active-high asserted", 32'(int_pin), 32'h1);
    wr_clr(8'hFF);
    chk("R9 active-high released", 32'(int_pin), 32'h0);
    chk("R7 cfg readback", 32'(cfg_rdata), 32'h01);

    cur_req = "R10";
    wr_cfg(8'h03);
    count_start();
    ev(ACK, DIN, 0);
    ev(ACK, DIN, 1);
    ev(ACK, DOUT, 2);
    idle(30);
    cnt_en = 0;
    chk("R10 pulse count", 32'(rises), 32'd3);
    chk("R10 asserted cycles", 32'(highs), 32'(3 * P));
    chk("R10 pulse spacing", 32'(last_rise - first_rise), 32'(2 * (P + 1)));

    cur_req = "R12";
    wr_clr(8'hFF);
    wr_en(8'hF7);
    count_start();
    ev(ACK, DIN, 3);
    idle(10);
    cnt_en = 0;
    chk("R12 masked no pulse", 32'(rises), 32'd0);
    chk("R12 masked flag in pulse mode", 32'(pend), 32'h08);

    cur_req = "R11";
    wr_clr(8'hFF);
    wr_en(8'hFF);
    wr_cfg(8'h23);
    ev(ACK, DIN, 4);
    idle(P + 2);
    bus_rst = 1; @(negedge clk); bus_rst = 0;
    chk("R11 policies cleared, pin bits kept", 32'(cfg_rdata), 32'h03);
    chk("R11 flags kept", 32'(pend), 32'h10);
    wr_clr(8'hFF);
    wr_cfg(8'h23);
    ev(NAK, DIN, 4);
    chk("R11 endpoint disarmed", 32'(pend), 32'h00);
    idle(P + 3);

    finish_run();
  end

endmodule